// File: doc/BRIEF.md
# Keyed Cache Set-Index Randomizer

This block turns a request address into a randomized cache set index. The index is a keyed function of the upper address bits. A new key therefore moves every line to a different set, and any eviction set an attacker has built stops working. Two function types can be chosen at run time: an XOR fold and a random-modulo permutation. A skew control decides how keys are used. With skew off, every way uses one shared key. With skew on, each way uses its own key, and the block drives one index per way.

Refills and coherence probes already carry the index that was chosen when the line was first requested. For these requests the first-access flag is clear, and the carried index passes through unchanged. Only privileged writes may change a key. An unprivileged write is dropped and raises a one-cycle error flag. At reset every key is loaded from a boot entropy word, so the set mapping differs from one boot to the next. The result is registered, one cycle after the request.

Top module: `set_index_randomizer`

## Requirements
- R1: `out_valid` equals `req_valid` delayed by one clock. In a cycle with no request, `out_idx` keeps its previous value.
- R2: Address fields are: line offset `req_addr[5:0]`, line index `I = req_addr[11:6]`, tag `T = req_addr[31:12]`. Key fields are: low part `KL = key[5:0]`, high part `KH = key[25:6]`. `fold(x)` is the XOR of the 6-bit chunks of the 20-bit value `x`, starting at bit 0, with the top chunk zero-padded. With `fn_sel = 0` (XOR fold), the generated index is `I ^ KL ^ fold(T ^ KH)`.
- R3: With `fn_sel = 1` (random modulo), the generated index is `I ^ KL ^ fold((T + KH) mod 2^20)`.
- R4: When `req_first = 0`, every way of `out_idx` equals `req_idx`, whatever the mode and the keys.
- R5: With `skew_en = 0`, every way is generated from key slot 0, so all ways carry the same index.
- R6: With `skew_en = 1`, way `w` (bits `[6w+5:6w]` of `out_idx`) is generated from key slot `w`.
- R7: A write with `kw_en = 1` and `kw_priv = 1` stores `kw_key` in slot `kw_way`. A request in that same cycle still uses the old key. Requests from the next cycle onward use the new key. No flush is needed.
- R8: A write with `kw_en = 1` and `kw_priv = 0` leaves every key unchanged. It sets `kw_illegal` high for exactly the next cycle.
- R9: After reset, `out_valid = 0`, `kw_illegal = 0`, and key slot `w` holds `boot_seed ^ (((w+1) * 0x9E3779B97F4A7C15) mod 2^26)`.
- R10: For a fixed tag and key, both functions map the 64 line-index values onto 64 distinct set indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_seed | input | 26 | Entropy word that seeds the keys at reset |
| fn_sel | input | 1 | Function type: 0 = XOR fold, 1 = random modulo |
| skew_en | input | 1 | 1 = one key per way, 0 = key slot 0 shared by all ways |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_first | input | 1 | 1 = generate the index, 0 = use the carried index |
| req_idx | input | 6 | Carried randomized index |
| kw_en | input | 1 | Key write strobe |
| kw_priv | input | 1 | Writer is in privileged mode |
| kw_way | input | 2 | Key slot to write |
| kw_key | input | 26 | New key value |
| kw_illegal | output | 1 | Unprivileged key write was rejected (one-cycle pulse) |
| out_valid | output | 1 | Registered request valid |
| out_idx | output | 24 | Per-way set indexes, way w at bits [6w+5:6w] |

## Verification
The bench runs a vector table that crosses the two function types with the skewed and shared modes. Some entries clear the first-access flag; these show that bypass wins over every mode. Addresses that differ only in tag, or only in line index, show which fields feed the fold. A full sweep of line indexes under one tag checks that each function is a permutation. Further tests change the keys: a write in the same cycle as a request, a write to a single way, a rejected unprivileged write, and a second reset with a different seed. Each test shows whether the mapping moved at exactly the cycle and in exactly the ways it should.

// File: rtl/setrand_pkg.sv
package setrand_pkg;
  typedef enum logic {
    FN_XORFOLD = 1'b0,
    FN_RMOD    = 1'b1
  } setrand_fn_e;

  localparam logic [63:0] SEED_SALT = 64'h9E3779B97F4A7C15;
endpackage

// File: rtl/setrand_keys.sv
module setrand_keys #(
  parameter int WAYS  = 4,
  parameter int KEY_W = 26,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [KEY_W-1:0]            boot_seed,
  input  logic                        kw_en,
  input  logic                        kw_priv,
  input  logic [WAY_W-1:0]            kw_way,
  input  logic [KEY_W-1:0]            kw_key,
  output logic [WAYS-1:0][KEY_W-1:0]  keys,
  output logic                        kw_illegal
);
  import setrand_pkg::*;

  localparam logic [KEY_W-1:0] SALT = KEY_W'(SEED_SALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) begin
        keys[w] <= boot_seed ^ KEY_W'(KEY_W'(w + 1) * SALT);
      end
      kw_illegal <= 1'b0;
    end else begin
      kw_illegal <= kw_en && !kw_priv;
      if (kw_en && kw_priv && (int'(kw_way) < WAYS)) begin
        keys[kw_way] <= kw_key;
      end
    end
  end

  // R8
  unpriv_keys_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (kw_en && !kw_priv) |=> $stable(keys));
  // R8
  illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    kw_illegal |-> $past(kw_en && !kw_priv));
endmodule

// File: rtl/setrand_fn.sv
module setrand_fn #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 6,
  parameter int KEY_W = TAG_W + IDX_W
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [IDX_W-1:0] line_idx,
  input  logic [KEY_W-1:0] key,
  input  logic             fn_sel,
  output logic [IDX_W-1:0] set_idx
);
  import setrand_pkg::*;

  localparam int NCH   = (TAG_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [TAG_W-1:0] key_hi;
  logic [IDX_W-1:0] key_lo;
  logic [TAG_W-1:0] mixed;
  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] folded;

  assign key_lo = key[IDX_W-1:0];
  assign key_hi = key[KEY_W-1:IDX_W];

  always_comb begin
    if (setrand_fn_e'(fn_sel) == FN_RMOD) mixed = tag + key_hi;
    else                                   mixed = tag ^ key_hi;
    padded = PAD_W'(mixed);
    folded = '0;
    for (int c = 0; c < NCH; c++) begin
      folded = folded ^ padded[c*IDX_W +: IDX_W];
    end
    set_idx = line_idx ^ key_lo ^ folded;
  end
endmodule

// File: rtl/set_index_randomizer.sv
module set_index_randomizer #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int KEY_W = TAG_W + IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [KEY_W-1:0]      boot_seed,
  input  logic                  fn_sel,
  input  logic                  skew_en,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_first,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic                  kw_en,
  input  logic                  kw_priv,
  input  logic [WAY_W-1:0]      kw_way,
  input  logic [KEY_W-1:0]      kw_key,
  output logic                  kw_illegal,
  output logic                  out_valid,
  output logic [WAYS*IDX_W-1:0] out_idx
);
  logic [WAYS-1:0][KEY_W-1:0] keys;
  logic [WAYS*IDX_W-1:0]      gen_idx;
  logic [WAYS*IDX_W-1:0]      nxt_idx;
  logic [TAG_W-1:0]           req_tag;
  logic [IDX_W-1:0]           req_line;

  assign req_line = req_addr[OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];

  setrand_keys #(.WAYS(WAYS), .KEY_W(KEY_W), .WAY_W(WAY_W)) u_keys (
    .clk(clk), .rst(rst), .boot_seed(boot_seed),
    .kw_en(kw_en), .kw_priv(kw_priv), .kw_way(kw_way), .kw_key(kw_key),
    .keys(keys), .kw_illegal(kw_illegal)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [KEY_W-1:0] way_key;
    assign way_key = skew_en ? keys[w] : keys[0];
    setrand_fn #(.TAG_W(TAG_W), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_fn (
      .tag(req_tag), .line_idx(req_line), .key(way_key),
      .fn_sel(fn_sel), .set_idx(gen_idx[w*IDX_W +: IDX_W])
    );
  end

  assign nxt_idx = req_first ? gen_idx : {WAYS{req_idx}};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) out_idx <= nxt_idx;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && $stable(out_idx)));
  // R4
  bypass_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_first) |=> (out_idx == {WAYS{$past(req_idx)}}));
  // R5
  shared_key_ways_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_first && !skew_en) |=> (out_idx == {WAYS{out_idx[IDX_W-1:0]}}));
endmodule

// File: tb/set_index_randomizer_tb.sv
module set_index_randomizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [25:0] SALT = 26'(64'h9E3779B97F4A7C15);
  localparam logic [25:0] SEED_A = 26'h2C4_1F3A;
  localparam logic [25:0] SEED_B = 26'h13B_77E5;
  // {addr[31:0], first, fn, skew, carried[5:0]}
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 1'b0, 1'b0, 6'd0},
    {32'h0000_0040, 1'b1, 1'b0, 1'b0, 6'd0},
    {32'h0000_1040, 1'b1, 1'b0, 1'b0, 6'd0},
    {32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 6'd0},
    {32'h1234_5678, 1'b1, 1'b0, 1'b1, 6'd0},
    {32'h1234_5678, 1'b1, 1'b1, 1'b1, 6'd0},
    {32'hFFFF_FFC0, 1'b1, 1'b1, 1'b0, 6'd0},
    {32'hCAFE_0A80, 1'b0, 1'b0, 1'b1, 6'd37},
    {32'hCAFE_0A80, 1'b0, 1'b1, 1'b0, 6'd5},
    {32'h8000_0FC0, 1'b1, 1'b1, 1'b1, 6'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [25:0] boot_seed = SEED_A;
  logic fn_sel = 1'b0, skew_en = 1'b0, req_valid = 1'b0, req_first = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_idx = '0;
  logic kw_en = 1'b0, kw_priv = 1'b0;
  logic [1:0]  kw_way = '0;
  logic [25:0] kw_key = '0;
  logic kw_illegal, out_valid;
  logic [23:0] out_idx;

  int total = 0;
  int bad = 0;
  logic [25:0] mk [4];

  set_index_randomizer u_dut (
    .clk(clk), .rst(rst), .boot_seed(boot_seed), .fn_sel(fn_sel), .skew_en(skew_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_first(req_first), .req_idx(req_idx),
    .kw_en(kw_en), .kw_priv(kw_priv), .kw_way(kw_way), .kw_key(kw_key),
    .kw_illegal(kw_illegal), .out_valid(out_valid), .out_idx(out_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] model_fn(logic [31:0] a, logic [25:0] k, logic fn);
    logic [19:0] t, m;
    t = a[31:12];
    m = fn ? (t + k[25:6]) : (t ^ k[25:6]);
    return a[11:6] ^ k[5:0] ^ m[5:0] ^ m[11:6] ^ m[17:12] ^ {4'b0, m[19:18]};
  endfunction

  function automatic logic [23:0] model_out(logic [31:0] a, logic first, logic fn,
                                            logic skew, logic [5:0] carried);
    logic [23:0] r;
    for (int w = 0; w < 4; w++) begin
      if (!first) r[w*6 +: 6] = carried;
      else        r[w*6 +: 6] = model_fn(a, skew ? mk[w] : mk[0], fn);
    end
    return r;
  endfunction

  task automatic seed_model(logic [25:0] s);
    for (int w = 0; w < 4; w++) mk[w] = s ^ 26'(26'(w + 1) * SALT);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the result registered
  task automatic do_req(logic [31:0] a, logic first, logic fn, logic skew, logic [5:0] carried);
    req_addr = a; req_first = first; fn_sel = fn; skew_en = skew; req_idx = carried;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset(logic [25:0] s);
    boot_seed = s;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state of the outputs
    check("R9 out_valid in reset", 64'(out_valid), 64'd0);
    check("R9 kw_illegal in reset", 64'(kw_illegal), 64'd0);
    rst = 1'b0;
    seed_model(s);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    logic [63:0] seen;
    do_reset(SEED_A);

    // R9 keys seeded from boot_seed, seen through skewed XOR-fold output
    do_req(32'hA5A5_5A40, 1'b1, 1'b0, 1'b1, 6'd0);
    check("R9 seeded keys", 64'(out_idx), 64'(model_out(32'hA5A5_5A40, 1'b1, 1'b0, 1'b1, 6'd0)));

    // R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][40:9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:0]);
      check(VEC[i][8] ? (VEC[i][7] ? "R3 random-modulo" : "R2 xor-fold") : "R4 bypass",
            64'(out_idx),
            64'(model_out(VEC[i][40:9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:0])));
      check("R1 valid after request", 64'(out_valid), 64'd1);
    end

    // R5 shared mode: ways identical
    do_req(32'h7777_1240, 1'b1, 1'b1, 1'b0, 6'd0);
    check("R5 shared ways equal", 64'(out_idx), 64'({4{out_idx[5:0]}}));

    // R1 idle cycle holds the index and drops valid
    held = out_idx;
    @(negedge clk);
    check("R1 idle valid", 64'(out_valid), 64'd0);
    check("R1 idle hold", 64'(out_idx), 64'(held));

    // R7 write in same cycle as request uses old key, next request uses new key
    kw_en = 1'b1; kw_priv = 1'b1; kw_way = 2'd0; kw_key = 26'h0ABC_DEF;
    do_req(32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 6'd0);
    kw_en = 1'b0;
    check("R7 same-cycle old key", 64'(out_idx),
          64'(model_out(32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 6'd0)));
    mk[0] = 26'h0ABC_DEF;
    do_req(32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 6'd0);
    check("R7 new key applied", 64'(out_idx),
          64'(model_out(32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 6'd0)));

    // R8 unprivileged write: flag pulse, key unchanged
    kw_en = 1'b1; kw_priv = 1'b0; kw_way = 2'd1; kw_key = 26'h3FF_FFFF;
    @(negedge clk);
    kw_en = 1'b0;
    check("R8 illegal flag set", 64'(kw_illegal), 64'd1);
    do_req(32'h5555_AAC0, 1'b1, 1'b1, 1'b1, 6'd0);
    check("R8 illegal flag one cycle", 64'(kw_illegal), 64'd0);
    check("R8 key unchanged", 64'(out_idx),
          64'(model_out(32'h5555_AAC0, 1'b1, 1'b1, 1'b1, 6'd0)));

    // R6 privileged write to way 2 only moves way 2 in skewed mode
    kw_en = 1'b1; kw_priv = 1'b1; kw_way = 2'd2; kw_key = 26'h155_5555;
    @(negedge clk);
    kw_en = 1'b0;
    mk[2] = 26'h155_5555;
    do_req(32'h5555_AAC0, 1'b1, 1'b1, 1'b1, 6'd0);
    check("R6 per-way key", 64'(out_idx),
          64'(model_out(32'h5555_AAC0, 1'b1, 1'b1, 1'b1, 6'd0)));

    // R10 permutation over all line indexes for both functions
    for (int f = 0; f < 2; f++) begin
      seen = '0;
      for (int j = 0; j < 64; j++) begin
        do_req({20'hC3A5E, 6'(j), 6'h00}, 1'b1, 1'(f), 1'b0, 6'd0);
        seen[out_idx[5:0]] = 1'b1;
      end
      check(f ? "R10 random-modulo permutation" : "R10 xor-fold permutation",
            64'($countones(seen)), 64'd64);
    end

    // R9 second boot with a different seed
    do_reset(SEED_B);
    do_req(32'hA5A5_5A40, 1'b1, 1'b0, 1'b1, 6'd0);
    check("R9 reseeded keys", 64'(out_idx), 64'(model_out(32'hA5A5_5A40, 1'b1, 1'b0, 1'b1, 6'd0)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule